// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a slave port that lets a host reach a bank of 128 registers, each 8 bits wide, over three wires: an active-low frame select, a serial clock and one data line used in both directions. Every frame is 16 bits long. It carries a direction flag, then a 7-bit register index, then 8 bits of data. On a write the host sends the data and the port stores it. On a read the port takes over the data line halfway through the frame and shifts the stored byte back out.

All three serial inputs are brought into the system clock domain through synchronizer chains. Serial clock edges are detected in that domain, so the serial clock must run well below the system clock. The pad is not part of the block. The port provides an output value and an output enable, and the pad cell outside the block combines them into the tri-state line.

Top module: `tw_reg_port`

## Requirements
- R1: After reset, register `a` holds `{1'b0, a} ^ 8'h5A` and the output enable `sdio_oe` is low.
- R2: A frame is the serial clock rising edges seen while `sen_n` is low, with bits sent most significant first. Bit 0 is the direction (0 = write, 1 = read), bits 1 to 7 are the register index, and bits 8 to 15 are the data.
- R3: A complete write frame stores its 8 data bits in the addressed register. All other registers keep their values.
- R4: A read frame returns the addressed register MSB first. Each bit is driven after a falling edge of the serial clock, starting with the falling edge that follows the 8th rising edge, and it stays valid through the next rising edge.
- R5: `sdio_oe` is high only during the data phase of a read, from the falling edge after the 8th rising edge until `sen_n` is seen high. It is low during write frames and during the header.
- R6: A write frame that ends (`sen_n` high) before its 16th rising edge changes no register.
- R7: While `sen_n` is high, the bit counter is held at zero and serial clock edges are ignored. Every frame therefore starts at bit 0.
- R8: Serial clock edges after the 16th in a frame are ignored. They neither change the stored data nor disturb the byte being read back.
- R9: A read frame leaves the register it reads unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sen_n | input | 1 | Frame select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from the host, asynchronous to clk |
| sdio_in | input | 1 | Value seen on the shared data line |
| sdio_out | output | 1 | Value the port drives onto the data line |
| sdio_oe | output | 1 | High when the port drives the data line |

## Verification
Some properties hold on every cycle and are checked that way. The bit counter never passes the frame length and is cleared whenever the frame select is idle. The output enable drops once the select is idle, and it can only turn on at the end of a read header. The driven bit changes only on a detected falling edge. Register writes happen only at the close of a full frame whose direction flag is write. The actual register contents cannot be seen cycle by cycle. Reset values, stored write data, address decoding, discarded short frames, ignored surplus clocks and the absence of read side effects only show up in the bytes that the bench's read frames bring back.

// File: rtl/twp_pkg.sv
package twp_pkg;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int SH_W       = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;

    localparam logic [DATA_W-1:0] RST_MASK = 8'h5A;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] reset_value(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ADDR_W-1:0] = a;
        return w ^ RST_MASK;
    endfunction
endpackage

// File: rtl/twp_sync.sv
module twp_sync #(
    parameter int             N       = 3,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dsync,
    output logic [N-1:0] drise,
    output logic [N-1:0] dfall
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {(STAGES+1){RST_VAL[g]}};
            else     chain <= {chain[STAGES-1:0], din[g]};
        end
        assign dsync[g] = chain[STAGES-1];
        assign drise[g] = chain[STAGES-1] & ~chain[STAGES];
        assign dfall[g] = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/twp_frame.sv
module twp_frame
    import twp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr,
    output logic              sdo,
    output logic              oe,
    output cnt_t              bit_cnt,
    output logic              hdr_rd
);
    logic [SH_W-2:0]   sh;
    hdr_t              hdr;
    logic [DATA_W-1:0] dout;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            sh      <= '0;
            hdr     <= '0;
            dout    <= '0;
            oe      <= 1'b0;
        end else if (idle) begin
            bit_cnt <= '0;
            oe      <= 1'b0;
        end else begin
            if (rise && bit_cnt != cnt_t'(FRAME_BITS)) begin
                sh      <= {sh[SH_W-3:0], sdi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == cnt_t'(HDR_BITS - 1))
                    hdr <= hdr_t'({sh[HDR_BITS-2:0], sdi});
            end
            if (fall && hdr.rd) begin
                if (bit_cnt == cnt_t'(HDR_BITS)) begin
                    dout <= rdata;
                    oe   <= 1'b1;
                end else if (oe && bit_cnt < cnt_t'(FRAME_BITS)) begin
                    dout <= dout << 1;
                end
            end
        end
    end

    assign rd_addr = hdr.addr;
    assign hdr_rd  = hdr.rd;
    assign sdo     = oe & dout[DATA_W-1];

    always_comb begin
        wr.en   = ~idle & rise & ~hdr.rd & (bit_cnt == cnt_t'(FRAME_BITS - 1));
        wr.addr = hdr.addr;
        wr.data = {sh[DATA_W-2:0], sdi};
    end
endmodule

// File: rtl/twp_regfile.sv
module twp_regfile
    import twp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= reset_value(ADDR_W'(i));
        end else if (wr.en) begin
            mem[wr.addr] <= wr.data;
        end
    end

    assign rdata = mem[rd_addr];
endmodule

// File: rtl/tw_reg_port.sv
module tw_reg_port
    import twp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sen_n,
    input  logic sclk,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe
);
    localparam int L_SCLK = 0;
    localparam int L_SDI  = 1;
    localparam int L_SEN  = 2;
    localparam int NLINES = 3;

    logic [NLINES-1:0] raw, syn, rs, fl;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rdata;
    wr_req_t           wr_req;
    cnt_t              bit_cnt;
    logic              hdr_rd, sen_sync, sclk_rise, sclk_fall, wr_en;

    assign raw = {sen_n, sdio_in, sclk};

    twp_sync #(
        .N      (NLINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw),
        .dsync(syn),
        .drise(rs),
        .dfall(fl)
    );

    assign sen_sync  = syn[L_SEN];
    assign sclk_rise = rs[L_SCLK];
    assign sclk_fall = fl[L_SCLK];

    twp_frame u_frame (
        .clk    (clk),
        .rst    (rst),
        .idle   (sen_sync),
        .rise   (sclk_rise),
        .fall   (sclk_fall),
        .sdi    (syn[L_SDI]),
        .rdata  (rdata),
        .rd_addr(rd_addr),
        .wr     (wr_req),
        .sdo    (sdio_out),
        .oe     (sdio_oe),
        .bit_cnt(bit_cnt),
        .hdr_rd (hdr_rd)
    );

    assign wr_en = wr_req.en;

    twp_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_req),
        .rd_addr(rd_addr),
        .rdata  (rdata)
    );

    logic unused_edges;
    assign unused_edges = ^{rs[L_SEN], fl[L_SEN], rs[L_SDI], fl[L_SDI]};
endmodule

// File: rtl/tw_reg_port_chk.sv
module tw_reg_port_chk
    import twp_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic sdio_oe,
    input logic sdio_out,
    input logic sen_idle,
    input logic rise,
    input logic fall,
    input cnt_t bit_cnt,
    input logic hdr_rd,
    input logic wr_en
);
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= cnt_t'(FRAME_BITS));

    assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (rst)
        sen_idle |=> bit_cnt == '0);

    assert_oe_idle_R5: assert property (@(posedge clk) disable iff (rst)
        sen_idle |=> !sdio_oe);

    assert_oe_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sdio_oe) |-> (bit_cnt == cnt_t'(HDR_BITS)) && hdr_rd);

    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (sdio_oe && $past(sdio_oe) && !$past(fall)) |-> $stable(sdio_out));

    assert_full_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> bit_cnt == cnt_t'(FRAME_BITS));

    assert_no_read_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !hdr_rd && !sdio_oe);

    assert_edges_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(rise && fall));
endmodule

bind tw_reg_port tw_reg_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sdio_oe (sdio_oe),
    .sdio_out(sdio_out),
    .sen_idle(sen_sync),
    .rise    (sclk_rise),
    .fall    (sclk_fall),
    .bit_cnt (bit_cnt),
    .hdr_rd  (hdr_rd),
    .wr_en   (wr_en)
);

// File: tb/test_tw_reg_port.sv
module test_tw_reg_port;
    localparam int HALF = 8;

    logic clk = 0, rst = 1;
    logic sen_n = 1, sclk = 0, sdio_in = 0;
    logic sdio_out, sdio_oe;

    int n_chk = 0, n_bad = 0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] got_q[$];
    logic [7:0] model[128];

    always #10 clk = ~clk;

    tw_reg_port i_tw_reg_port (
        .clk(clk), .rst(rst), .sen_n(sen_n), .sclk(sclk),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [15:0] bits, input int nbits, input int extra,
                             input bit is_rd, output logic [7:0] got, output bit oe_bad);
        got = '0;
        oe_bad = 0;
        sen_n = 0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdio_in = bits[15-i];
            tick(HALF);
            if (is_rd && i >= 8) begin
                if (!sdio_oe) oe_bad = 1;
                got[15-i] = sdio_out;
            end else if (sdio_oe) begin
                oe_bad = 1;
            end
            sclk = 1;
            tick(HALF);
            sclk = 0;
        end
        for (int k = 0; k < extra; k++) begin
            sdio_in = ~sdio_in;
            tick(HALF);
            sclk = 1;
            tick(HALF);
            sclk = 0;
        end
        tick(HALF);
        sen_n = 1;
        tick(2 * HALF);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d, input int nbits, input int extra);
        logic [7:0] g;
        bit ob;
        run_frame({1'b0, a, d}, nbits, extra, 0, g, ob);
        check("R5 oe during write", {7'b0, ob}, 8'h00);
        if (nbits == 16) model[a] = d;
    endtask

    task automatic rd(input logic [6:0] a, input string req, input int extra);
        logic [7:0] g;
        bit ob;
        exp_t e;
        e.val = model[a];
        e.req = req;
        exp_q.push_back(e);
        run_frame({1'b1, a, 8'h00}, 16, extra, 1, g, ob);
        got_q.push_back(g);
        check("R5 oe only in read data phase", {7'b0, ob}, 8'h00);
        check("R5 oe low after frame", {7'b0, sdio_oe}, 8'h00);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (got_q.size() > 0 && exp_q.size() > 0) begin
                exp_t e;
                logic [7:0] g;
                e = exp_q.pop_front();
                g = got_q.pop_front();
                check(e.req, g, e.val);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] g;
        bit ob;
        for (int a = 0; a < 128; a++) model[a] = {1'b0, 7'(a)} ^ 8'h5A;
        tick(5);
        rst = 0;
        tick(5);
        check("R1 oe after reset", {7'b0, sdio_oe}, 8'h00);
        check("R1 data out after reset", {7'b0, sdio_out}, 8'h00);

        rd(7'h00, "R1 reset value 00", 0);
        rd(7'h7F, "R1 reset value 7F", 0);
        rd(7'h2A, "R1 reset value 2A", 0);

        wr(7'h05, 8'hC3, 16, 0);
        wr(7'h7F, 8'h00, 16, 0);
        wr(7'h00, 8'hFF, 16, 0);
        rd(7'h05, "R3 write 05", 0);
        rd(7'h7F, "R3 write 7F", 0);
        rd(7'h00, "R3 write 00", 0);
        rd(7'h04, "R3 neighbour 04", 0);
        rd(7'h06, "R3 neighbour 06", 0);

        wr(7'h40, 8'h11, 16, 0);
        wr(7'h01, 8'h22, 16, 0);
        rd(7'h40, "R2 address MSB", 0);
        rd(7'h01, "R2 address LSB", 0);

        rd(7'h05, "R9 first read", 0);
        rd(7'h05, "R9 repeated read", 0);

        wr(7'h10, 8'h99, 12, 0);
        wr(7'h11, 8'h66, 15, 0);
        wr(7'h12, 8'h55, 3, 0);
        rd(7'h10, "R6 aborted at 12 bits", 0);
        rd(7'h11, "R6 aborted at 15 bits", 0);
        rd(7'h12, "R6 aborted in header", 0);

        sdio_in = 1;
        for (int k = 0; k < 5; k++) begin
            sclk = 1; tick(HALF);
            sclk = 0; tick(HALF);
        end
        wr(7'h20, 8'h3C, 16, 0);
        rd(7'h20, "R7 idle clocks ignored", 0);

        wr(7'h30, 8'h81, 16, 4);
        rd(7'h30, "R8 extra clocks on write", 0);
        rd(7'h30, "R8 extra clocks on read", 5);

        run_frame({1'b1, 7'h30, 8'h00}, 12, 0, 1, g, ob);
        check("R5 oe low after aborted read", {7'b0, sdio_oe}, 8'h00);
        rd(7'h30, "R4 read after aborted read", 0);

        wr(7'h55, 8'hA5, 16, 0);
        rd(7'h55, "R4 alternating bits", 0);

        while (got_q.size() > 0) tick(1);
        tick(4);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule